// File: doc/BRIEF.md
# Latched serial-to-parallel shift register

This block turns a slow serial stream into a wide parallel word. Each rising edge on an external shift clock moves one data bit into the bottom stage of a shift chain, and every stage moves up by one. A second, independent storage clock copies the whole chain into a holding register, which feeds the parallel outputs. The top stage of the chain is also brought out as a serial output, so that several blocks can be chained into one longer register.

The two external clocks, the data input and the clear input are all sampled in a single system clock domain. Each of them passes through a synchronizer, and a rising-edge detector marks each clock edge. The external clocks must stay at each level for at least two system clock periods, which means they must run slower than a quarter of the system clock.

An active-low clear empties the shift chain at once and leaves the holding register alone. The clear is applied asynchronously and released in step with the system clock. An active-low output enable drives a pad drive-enable output: the pads drive the holding register value when it is asserted and are high-impedance otherwise. The width is the parameter N (default 8).

Top module: `ser2par_latch`

## Requirements
- R1: On each rising edge of `shift_clk`, stage 0 of the chain takes `ser_in` and each stage k takes the old value of stage k-1.
- R2: On each rising edge of `store_clk`, all N chain stages are copied at once into the holding register, which appears on `par_q`. Bit k of `par_q` is chain stage k.
- R3: `ser_out` always equals chain stage N-1. It therefore carries the value stage N-2 held before the latest shift edge.
- R4: While `clear_n` is low, every chain stage and `ser_out` are 0, and shift edges have no effect. The holding register and `par_q` keep their values.
- R5: A `store_clk` rising edge while `clear_n` is low loads all zeros into the holding register.
- R6: `par_drive` is 1 while `out_en_n` is 0 and is 0 while `out_en_n` is 1 (pads high-impedance). `par_q` and `ser_out` do not depend on `out_en_n`.
- R7: When `shift_clk` and `store_clk` rise together, the holding register receives the chain contents from before that edge. It therefore stays one shift behind.
- R8: Each external rising edge acts exactly once. Its effect is visible at the outputs no later than four system clocks after the edge.
- R9: If `ser_out` of one block feeds `ser_in` of a second block on the same clocks, the two act as one 2N-stage chain.
- R10: After the system reset `rst_n`, the chain, the holding register, `ser_out` and `par_q` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | System reset, active low, asynchronous assert |
| shift_clk | input | 1 | External shift clock, acts on its rising edge |
| store_clk | input | 1 | External storage clock, acts on its rising edge |
| clear_n | input | 1 | Active-low clear of the shift chain |
| out_en_n | input | 1 | Active-low output enable for the parallel pads |
| ser_in | input | 1 | Serial data input |
| par_q | output | N | Holding register value |
| par_drive | output | 1 | Pad drive enable for par_q; 0 means high-impedance |
| ser_out | output | 1 | Serial cascade output, chain stage N-1 |

## Verification
The hardest case to reach is the tied-clock lag. Both external clocks must rise in the same system cycle, so that the storage capture and the shift happen on one internal edge. The bench therefore drives both clock inputs in the same statement, then compares the holding register with the model's pre-shift contents.

Clear isolation is the other delicate case. The bench loads a known word into the holding register and then holds the clear. While the clear is held it issues shift pulses, and then a storage pulse, checking that the held word survives until that storage edge turns it into zeros.

A second instance is wired to the serial output for the whole run. This way, every shift also exercises the chaining path against a 2N-bit model.

// File: rtl/ser2par_pkg.sv
package ser2par_pkg;
  localparam int unsigned SYNC_STAGES_DEF = 2;
  localparam int unsigned WIDTH_DEF       = 8;
endpackage

// File: rtl/ser2par_rst_sync.sv
module ser2par_rst_sync #(
  parameter int unsigned STAGES = ser2par_pkg::SYNC_STAGES_DEF
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/ser2par_bit_sync.sv
module ser2par_bit_sync #(
  parameter int unsigned STAGES = ser2par_pkg::SYNC_STAGES_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign dout = sr_q[STAGES-1];
endmodule

// File: rtl/ser2par_edge_sync.sv
module ser2par_edge_sync #(
  parameter int unsigned STAGES = ser2par_pkg::SYNC_STAGES_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext,
  output logic rise
);
  localparam int unsigned LEN = STAGES + 1;
  logic [LEN-1:0] sr_q;
  logic [LEN-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[LEN-2:0], ext};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign rise = sr_q[STAGES-1] & ~sr_q[STAGES];

  // an edge produces a single-cycle pulse, never two in a row
  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/ser2par_shift_chain.sv
module ser2par_shift_chain #(
  parameter int unsigned N = ser2par_pkg::WIDTH_DEF
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         adv,
  input  logic         din,
  output logic [N-1:0] stages
);
  logic [N-1:0] stg_q;
  logic [N-1:0] stg_d;

  generate
    for (genvar k = 0; k < N; k++) begin : g_stage
      if (k == 0) begin : g_head
        always_comb stg_d[k] = adv ? din : stg_q[k];
      end else begin : g_body
        always_comb stg_d[k] = adv ? stg_q[k-1] : stg_q[k];
      end
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) stg_q[k] <= 1'b0;
        else        stg_q[k] <= stg_d[k];
      end
    end
  endgenerate

  assign stages = stg_q;

  assert_shift_move_R1: assert property (@(posedge clk) disable iff (!clr_n)
    adv |=> (stg_q[0] == $past(din)) && (stg_q[N-1:1] == $past(stg_q[N-2:0])));
  assert_shift_hold_R8: assert property (@(posedge clk) disable iff (!clr_n)
    !adv |=> $stable(stg_q));
endmodule

// File: rtl/ser2par_hold_reg.sv
module ser2par_hold_reg #(
  parameter int unsigned N = ser2par_pkg::WIDTH_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] hold_q;
  logic [N-1:0] hold_d;

  always_comb begin
    hold_d = load ? d : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  assign q = hold_q;

  assert_load_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> q == $past(d));
  assert_load_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
endmodule

// File: rtl/ser2par_latch.sv
module ser2par_latch #(
  parameter int unsigned N     = ser2par_pkg::WIDTH_DEF,
  parameter int unsigned SYNCS = ser2par_pkg::SYNC_STAGES_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_clk,
  input  logic         store_clk,
  input  logic         clear_n,
  input  logic         out_en_n,
  input  logic         ser_in,
  output logic [N-1:0] par_q,
  output logic         par_drive,
  output logic         ser_out
);
  logic sys_rst_n;
  logic clr_raw_n;
  logic clr_rst_n;
  logic shift_rise;
  logic store_rise;
  logic din_sync;
  logic [N-1:0] chain;

  assign clr_raw_n = rst_n & clear_n;

  ser2par_rst_sync #(.STAGES(SYNCS)) u_sys_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(sys_rst_n));

  ser2par_rst_sync #(.STAGES(SYNCS)) u_clr_rst (
    .clk(clk), .arst_n(clr_raw_n), .srst_n(clr_rst_n));

  ser2par_edge_sync #(.STAGES(SYNCS)) u_shift_edge (
    .clk(clk), .rst_n(sys_rst_n), .ext(shift_clk), .rise(shift_rise));

  ser2par_edge_sync #(.STAGES(SYNCS)) u_store_edge (
    .clk(clk), .rst_n(sys_rst_n), .ext(store_clk), .rise(store_rise));

  ser2par_bit_sync #(.STAGES(SYNCS)) u_din_sync (
    .clk(clk), .rst_n(sys_rst_n), .din(ser_in), .dout(din_sync));

  ser2par_shift_chain #(.N(N)) u_chain (
    .clk(clk), .clr_n(clr_rst_n), .adv(shift_rise),
    .din(din_sync), .stages(chain));

  ser2par_hold_reg #(.N(N)) u_hold (
    .clk(clk), .rst_n(sys_rst_n), .load(store_rise),
    .d(chain), .q(par_q));

  assign ser_out   = chain[N-1];
  assign par_drive = ~out_en_n;

  assert_clear_sout_R4: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !clr_rst_n |-> (ser_out == 1'b0));
  assert_clear_load_R5: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (!clr_rst_n && store_rise) |=> (par_q == '0));
  assert_tied_lag_R7: assert property (@(posedge clk) disable iff (!clr_rst_n)
    (store_rise && shift_rise) |=> (par_q == $past(chain)));
endmodule

// File: tb/tb_ser2par_latch.sv
`timescale 1ns/1ps
module tb_ser2par_latch;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n, shift_clk, store_clk, clear_n, out_en_n, ser_in;
  logic [N-1:0] par_q, par_q2;
  logic par_drive, par_drive2, ser_out, ser_out2;

  always #4 clk = ~clk;

  ser2par_latch #(.N(N)) dut (
    .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .store_clk(store_clk),
    .clear_n(clear_n), .out_en_n(out_en_n), .ser_in(ser_in),
    .par_q(par_q), .par_drive(par_drive), .ser_out(ser_out));

  ser2par_latch #(.N(N)) dut2 (
    .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .store_clk(store_clk),
    .clear_n(clear_n), .out_en_n(1'b0), .ser_in(ser_out),
    .par_q(par_q2), .par_drive(par_drive2), .ser_out(ser_out2));

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  // reference model: one bit queue for the whole 2N chain, index 0 = stage 0
  bit chain_m[$];
  logic [N-1:0] hold1_m, hold2_m;

  function automatic logic [N-1:0] seg(int base);
    logic [N-1:0] v;
    for (int k = 0; k < N; k++) v[k] = chain_m[base + k];
    return v;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  task automatic compare_all(string req);
    check(req, 32'(par_q), 32'(hold1_m));
    check(req, 32'(ser_out), 32'(chain_m[N-1]));
    check({req, "_R9"}, 32'(par_q2), 32'(hold2_m));
    check({req, "_R9"}, 32'(ser_out2), 32'(chain_m[2*N-1]));
  endtask

  // one external pulse on the chosen clocks; results checked 4 system clocks later
  task automatic pulse(bit sh, bit st, bit d, string req);
    @(negedge clk);
    ser_in = d;
    shift_clk = sh;
    store_clk = st;
    if (st) begin
      hold1_m = clear_n ? seg(0) : '0;
      hold2_m = clear_n ? seg(N) : '0;
    end
    if (sh && clear_n) begin
      chain_m.push_front(d);
      void'(chain_m.pop_back());
    end
    repeat (4) @(negedge clk);
    compare_all(req);
    shift_clk = 1'b0;
    store_clk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic shift_byte(logic [N-1:0] v);
    for (int k = N - 1; k >= 0; k--) pulse(1'b1, 1'b0, v[k], "R1");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_up();
  end

  initial begin
    rst_n = 1'b0; shift_clk = 1'b0; store_clk = 1'b0;
    clear_n = 1'b1; out_en_n = 1'b0; ser_in = 1'b0;
    for (int k = 0; k < 2 * N; k++) chain_m.push_back(1'b0);
    hold1_m = '0; hold2_m = '0;
    repeat (4) @(negedge clk);
    // R10 reset state
    check("R10", 32'(par_q), 32'h0);
    check("R10", 32'(ser_out), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R3 shifting two patterns, R2 latching
    shift_byte(8'hA5);
    pulse(1'b0, 1'b1, 1'b0, "R2");
    shift_byte(8'h3C);
    pulse(1'b0, 1'b1, 1'b1, "R2");
    check("R2", 32'(par_q), 32'h3C);
    check("R9", 32'(par_q2), 32'hA5);

    // R7 tied clocks: holding register one shift behind
    for (int k = 0; k < 5; k++) pulse(1'b1, 1'b1, k[0], "R7");

    // R6 output enable only touches the pad drive
    @(negedge clk);
    check("R6", 32'(par_drive), 32'h1);
    out_en_n = 1'b1;
    #1 check("R6", 32'(par_drive), 32'h0);
    check("R6", 32'(par_q), 32'(hold1_m));
    check("R6", 32'(ser_out), 32'(chain_m[N-1]));
    pulse(1'b1, 1'b1, 1'b1, "R6");
    out_en_n = 1'b0;
    #1 check("R6", 32'(par_drive), 32'h1);

    // R4 clear: chain and ser_out zero, holding register kept, shifts ignored
    shift_byte(8'hFF);
    pulse(1'b0, 1'b1, 1'b0, "R2");
    @(negedge clk);
    clear_n = 1'b0;
    for (int k = 0; k < 2 * N; k++) chain_m[k] = 1'b0;
    #1 check("R4", 32'(ser_out), 32'h0);
    check("R4", 32'(par_q), 32'hFF);
    pulse(1'b1, 1'b0, 1'b1, "R4");
    pulse(1'b1, 1'b0, 1'b1, "R4");
    check("R4", 32'(par_q), 32'hFF);
    // R5 storage edge during clear loads zeros
    pulse(1'b0, 1'b1, 1'b1, "R5");
    check("R5", 32'(par_q), 32'h0);
    clear_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8 R3 shifting resumes after release, chain continues through both blocks
    shift_byte(8'h81);
    shift_byte(8'h5A);
    pulse(1'b0, 1'b1, 1'b0, "R9");
    check("R9", 32'(par_q2), 32'h81);
    check("R3", 32'(ser_out), 32'h0);
    finish_up();
  end
endmodule